// File: doc/BRIEF.md
# Charge-Redistribution SAR Sequencer

This block is the digital controller of an N-bit successive-approximation converter built around a binary-weighted capacitor array. It runs entirely from the externally supplied sampling clock. When idle, it keeps the array tracking the analog input. A start pulse freezes the sample. The block then sets the bottom-plate switches to reference or ground, one capacitor at a time from the largest down, and reads a single comparator bit to settle each bit.

Every bit trial takes a programmable number of switch-settling cycles, followed by one comparator-sampling cycle. The comparator is read only in the sampling cycle. After the least significant bit is decided, the block drops busy and pulses end-of-conversion for one cycle. The final switch pattern appears on the data output, which holds until the next conversion completes. The block then returns the array to tracking.

Top module: `sar_cdac_ctrl`

## Requirements
- R1: While idle, the block drives both sampling-switch outputs high (1 = closed) and every bottom-plate switch bit low (0 = ground, 1 = reference). Busy and end-of-conversion are low.
- R2: A start pulse sampled high while idle leads, on the next cycle, to both sampling switches open and busy high. In that capture cycle all bottom-plate bits are at ground.
- R3: In the cycle after the capture cycle, only the most significant bottom-plate bit (bit N-1) is at reference. Each bit trial lasts SETTLE_CYC settling cycles followed by one comparator-sampling cycle.
- R4: The comparator input is taken only in the last cycle of each trial. Its value in the settling cycles has no effect on the result.
- R5: At the end of each trial, a comparator value of 1 leaves the bit under test at reference and 0 returns it to ground. On the same edge the next lower bit goes to reference, and already decided higher bits keep their values.
- R6: On the edge that decides bit 0, busy falls and end-of-conversion rises. The bottom-plate bits and the data output both show the final code. Busy stays high for exactly 1 + N*(SETTLE_CYC+1) cycles.
- R7: End-of-conversion lasts a single cycle. In the following cycle the block is back in tracking as in R1.
- R8: The data output changes only on the cycle end-of-conversion rises. It holds its value while idle and during the following conversion.
- R9: A start pulse while busy is high, or during the end-of-conversion cycle, is ignored. It changes neither the result nor the timing, and it starts no new conversion.
- R10: An active-low asynchronous reset forces tracking with all bottom-plate bits at ground, busy and end-of-conversion low, and the data output zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; every phase is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Comparator result; 1 means the test level is below the input |
| bot_sw_o | output | N | Bottom-plate switch selects, 1 = reference, 0 = ground |
| samp_in_sw_o | output | 1 | Input sampling switch, 1 = closed |
| samp_cm_sw_o | output | 1 | Common-node switch, 1 = closed |
| busy_o | output | 1 | High from capture until the last bit decision |
| eoc_o | output | 1 | One-cycle end-of-conversion strobe |
| data_o | output | N | Converted code, held until the next completion |

## Verification
A trial register that loses or duplicates its one-hot bit shows up on the bottom-plate lines within one trial. It either drops the reference pattern to all-ground or lights two bits in the same cycle, and the final code then differs from the input level the comparator model was given. A sequencer that reads the comparator in a settling cycle is exposed because the bench drives the inverted answer in exactly those cycles. A wrong state count shifts the end-of-conversion pulse away from cycle 1 + N*(SETTLE_CYC+1) after capture, which the bench sees on the same conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [2:0] {
      ST_TRACK  = 3'd0,
      ST_HOLD   = 3'd1,
      ST_SETTLE = 3'd2,
      ST_SAMPLE = 3'd3,
      ST_DONE   = 3'd4
   } sar_state_e;

endpackage

// File: rtl/sar_phase_timer.sv
// Counts the settling sub-phase of one bit trial and flags its last cycle.
module sar_phase_timer #(
   parameter int SETTLE_CYC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic settle_done_o
);

   generate
      if (SETTLE_CYC == 1) begin : g_single
         // one settling cycle: the phase ends the cycle it starts
         logic unused_timer;
         assign unused_timer  = clk ^ rst_n;
         assign settle_done_o = run_i;
      end else begin : g_count
         localparam int CW = $clog2(SETTLE_CYC);
         localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (!run_i)         cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end

         assign settle_done_o = run_i && (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/sar_trial_reg.sv
// Holds the decided bits and the one-hot bit under test.
module sar_trial_reg #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         load_i,
   input  logic         decide_i,
   input  logic         cmp_i,
   output logic [N-1:0] bot_sw_o,
   output logic [N-1:0] code_next_o,
   output logic         last_o
);

   localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

   logic [N-1:0] trial_q;
   logic [N-1:0] code_q;

   assign code_next_o = cmp_i ? (code_q | trial_q) : code_q;
   assign last_o      = trial_q[0];
   assign bot_sw_o    = code_q | trial_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trial_q <= '0;
         code_q  <= '0;
      end else if (clear_i) begin
         trial_q <= '0;
         code_q  <= '0;
      end else if (load_i) begin
         trial_q <= MSB_ONLY;
         code_q  <= '0;
      end else if (decide_i) begin
         code_q  <= code_next_o;
         trial_q <= trial_q >> 1;
      end
   end

endmodule

// File: rtl/sar_seq_fsm.sv
// Phase sequencer: track, capture, settle/sample per bit, completion.
module sar_seq_fsm
   import sar_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic settle_done_i,
   input  logic last_i,
   output logic load_o,
   output logic settle_o,
   output logic decide_o,
   output logic clear_o,
   output logic track_o,
   output logic busy_o,
   output logic eoc_o
);

   sar_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_TRACK:  if (start_i) state_d = ST_HOLD;
         ST_HOLD:   state_d = ST_SETTLE;
         ST_SETTLE: if (settle_done_i) state_d = ST_SAMPLE;
         ST_SAMPLE: state_d = last_i ? ST_DONE : ST_SETTLE;
         ST_DONE:   state_d = ST_TRACK;
         default:   state_d = ST_TRACK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_TRACK;
      else        state_q <= state_d;
   end

   assign load_o   = (state_q == ST_HOLD);
   assign settle_o = (state_q == ST_SETTLE);
   assign decide_o = (state_q == ST_SAMPLE);
   assign clear_o  = (state_q == ST_DONE);
   assign track_o  = (state_q == ST_TRACK);
   assign busy_o   = (state_q == ST_HOLD) || (state_q == ST_SETTLE) ||
                     (state_q == ST_SAMPLE);
   assign eoc_o    = (state_q == ST_DONE);

endmodule

// File: rtl/sar_cdac_ctrl.sv
// Top of the successive-approximation switch sequencer.
module sar_cdac_ctrl #(
   parameter int N          = 8,
   parameter int SETTLE_CYC = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         cmp_i,
   output logic [N-1:0] bot_sw_o,
   output logic         samp_in_sw_o,
   output logic         samp_cm_sw_o,
   output logic         busy_o,
   output logic         eoc_o,
   output logic [N-1:0] data_o
);

   generate
      if (N < 2) begin : g_bad_width
         $error("sar_cdac_ctrl: N must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("sar_cdac_ctrl: SETTLE_CYC must be at least 1");
      end
   endgenerate

   logic         load, settle, decide, clear, track, last, settle_done;
   logic [N-1:0] code_next;
   logic [N-1:0] data_q;

   sar_seq_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .settle_done_i (settle_done),
      .last_i        (last),
      .load_o        (load),
      .settle_o      (settle),
      .decide_o      (decide),
      .clear_o       (clear),
      .track_o       (track),
      .busy_o        (busy_o),
      .eoc_o         (eoc_o)
   );

   sar_phase_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .run_i         (settle),
      .settle_done_o (settle_done)
   );

   sar_trial_reg #(.N(N)) u_trial (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear_i     (clear),
      .load_i      (load),
      .decide_i    (decide),
      .cmp_i       (cmp_i),
      .bot_sw_o    (bot_sw_o),
      .code_next_o (code_next),
      .last_o      (last)
   );

   // result register: loaded only by the final bit decision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              data_q <= '0;
      else if (decide && last) data_q <= code_next;
   end

   assign data_o       = data_q;
   assign samp_in_sw_o = track;
   assign samp_cm_sw_o = track;

endmodule

// File: rtl/sar_cdac_ctrl_chk.sv
module sar_cdac_ctrl_chk #(
   parameter int N          = 8,
   parameter int SETTLE_CYC = 1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start_i,
   input logic [N-1:0] bot_sw_o,
   input logic         samp_in_sw_o,
   input logic         samp_cm_sw_o,
   input logic         busy_o,
   input logic         eoc_o,
   input logic [N-1:0] data_o
);

   localparam int BUSY_LEN = 1 + N * (SETTLE_CYC + 1);
   localparam int BW = $clog2(BUSY_LEN + 2) + 1;
   localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

   logic [BW-1:0] busy_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_cnt_q <= '0;
      else if (busy_o) busy_cnt_q <= busy_cnt_q + 1'b1;
      else             busy_cnt_q <= '0;
   end

   // R1
   idle_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !eoc_o) |-> (samp_in_sw_o && samp_cm_sw_o && bot_sw_o == '0));

   // R2
   start_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !eoc_o && start_i) |=> (busy_o && !samp_in_sw_o && !samp_cm_sw_o && bot_sw_o == '0));

   // R3
   msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |=> (bot_sw_o == MSB_ONLY));

   // R6
   final_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |-> (!busy_o && bot_sw_o == data_o && busy_cnt_q == BW'(BUSY_LEN)));

   // R7
   eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc_o |=> (!eoc_o && samp_in_sw_o));

   // R8
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc_o |-> $stable(data_o));

endmodule

bind sar_cdac_ctrl sar_cdac_ctrl_chk #(.N(N), .SETTLE_CYC(SETTLE_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .bot_sw_o     (bot_sw_o),
   .samp_in_sw_o (samp_in_sw_o),
   .samp_cm_sw_o (samp_cm_sw_o),
   .busy_o       (busy_o),
   .eoc_o        (eoc_o),
   .data_o       (data_o)
);

// File: tb/sar_cdac_ctrl_tb.sv
module sar_cdac_ctrl_tb;

   localparam int W  = 8;
   localparam int ST = 1;
   localparam int NV = 8;
   localparam logic [W-1:0] VEC [NV] = '{8'h00, 8'hFF, 8'h80, 8'h7F,
                                         8'h55, 8'hAA, 8'h01, 8'hC3};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         cmp_i = 1'b0;
   logic [W-1:0] bot_sw_o, data_o;
   logic         samp_in_sw_o, samp_cm_sw_o, busy_o, eoc_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [W-1:0] prev_data = '0;

   always #2 clk = ~clk;

   sar_cdac_ctrl #(.N(W), .SETTLE_CYC(ST)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
      .bot_sw_o(bot_sw_o), .samp_in_sw_o(samp_in_sw_o), .samp_cm_sw_o(samp_cm_sw_o),
      .busy_o(busy_o), .eoc_o(eoc_o), .data_o(data_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(samp_in_sw_o && samp_cm_sw_o && !busy_o && !eoc_o && bot_sw_o == '0,
          req, {samp_in_sw_o, samp_cm_sw_o, busy_o, eoc_o, 8'h0, bot_sw_o},
          {4'b1100, 16'h0});
   endtask

   // one conversion against an ideal comparator for level vin
   task automatic run_conv(input logic [W-1:0] vin, input bit junk,
                           input bit mid_start, input bit eoc_start);
      bit path_ok = 1'b1;
      logic [W-1:0] exp_bot;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R2 capture cycle
      chk(busy_o && !samp_in_sw_o && !samp_cm_sw_o && bot_sw_o == '0, "R2",
          {busy_o, samp_in_sw_o, samp_cm_sw_o, bot_sw_o}, {3'b100, 8'h00});
      @(negedge clk);
      for (int b = 0; b < W; b++) begin
         for (int p = 0; p <= ST; p++) begin
            logic model;
            model = (bot_sw_o <= vin);
            // R4: only the sample cycle carries the true answer
            cmp_i = (p == ST) ? model : (junk ? ~model : model);
            if (p == 0) begin
               exp_bot = (vin & ~((W'(1) << (W - b)) - W'(1))) | (W'(1) << (W - 1 - b));
               if (b == 0) exp_bot = {1'b1, {(W-1){1'b0}}};
               if (bot_sw_o != exp_bot) path_ok = 1'b0;
               if (b == 0) chk(bot_sw_o == exp_bot, "R3", bot_sw_o, exp_bot);
               if (b == W/2) chk(data_o == prev_data, "R8", data_o, prev_data);
               if (mid_start && b == 3) start_i = 1'b1;
            end
            chk(busy_o || b == 0 && p == 0 && 1'b0, "R9", busy_o, 1);
            @(negedge clk);
            start_i = 1'b0;
         end
      end
      chk(path_ok, "R5", 0, 0);
      chk(eoc_o && !busy_o, "R6", {eoc_o, busy_o}, 2'b10);
      chk(data_o == vin, "R6", data_o, vin);
      chk(bot_sw_o == vin, "R6", bot_sw_o, vin);
      if (junk) chk(data_o == vin, "R4", data_o, vin);
      if (eoc_start) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(!eoc_o, "R7", eoc_o, 0);
      chk_idle("R7");
      if (eoc_start) chk(!busy_o && samp_in_sw_o, "R9", busy_o, 0);
      chk(data_o == vin, "R8", data_o, vin);
      prev_data = vin;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R10 reset state
      chk_idle("R10");
      chk(data_o == '0, "R10", data_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1");

      for (int i = 0; i < NV; i++) begin
         run_conv(VEC[i], i[0], i == 4, i == 5);
         @(negedge clk);
         chk_idle("R1");
      end

      // R8: output holds through an idle stretch
      repeat (5) @(negedge clk);
      chk(data_o == prev_data, "R8", data_o, prev_data);

      // R10: reset in the middle of a conversion
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk_idle("R10");
      chk(data_o == '0, "R10", data_o, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1");

      // a conversion after reset still converges
      prev_data = '0;
      run_conv(8'h96, 1'b1, 1'b1, 1'b0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule